// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block runs the self-calibration pass of an analog-to-digital converter. Software writes a control word over a simple register bus. The sequencer then steps through a fixed list of calibration measurements. For each one it raises a request towards an abstract conversion engine and waits for that engine's acknowledge. It captures every returned word into a result register: one offset-correction word, then seven plus-side words, then seven minus-side words.

A pass can end in two ways. If it runs to the end, the done flag rises, the fail flag stays clear, and an interrupt is raised when enabled. If it is cut short, the fail flag rises: any register write during the pass aborts it, and so does a stop-mode request. A start request is refused while hardware triggering is selected or while a stop request is present. With the default option, each side's gain word is derived in hardware from the captured words. The gain is half of the sum of six side words, with the top bit forced to one. The offset word is a 16-bit two's-complement, left-justified value. Software may also write it, and the other result words, while no pass is running, for example to restore saved values.

Top module: `adcal_seq`

## Requirements
- R1: A write to address 0 with bit 0 set (start), bit 1 clear (hardware trigger select) and no stop request present starts a pass on the next clock: `cal_active` goes high and `cal_fail` and `conv_done` go low. Bit 2 of that write sets the interrupt enable. Reading address 0 returns: bit 0 active, bit 1 trigger select, bit 2 interrupt enable, bit 3 done, bit 4 fail. All of these read 0 after reset.
- R2: A start write with bit 1 set, or with `stop_req` high in the same cycle, does not start a pass. Instead it sets `cal_fail`. A later write that does not start a pass leaves `cal_fail` set.
- R3: While a pass runs, a write to any address ends the pass on the next clock with `cal_active` low and `cal_fail` high. The written data is discarded. If an acknowledge arrives in the same cycle as the write, its word is not captured.
- R4: While a pass runs, `stop_req` ends the pass on the next clock with `cal_active` low and `cal_fail` high.
- R5: `cnv_req` is high exactly while a pass runs. `cnv_step` starts at 0, holds until `cnv_ack`, then advances by one, up to step 14.
- R6: The word on `cnv_data` at an acknowledge for step k is stored and read back at address k+1. Step 0 is the offset, steps 1 to 7 are the plus side (first word unused by the gain), and steps 8 to 14 are the minus side. While idle, writes to addresses 1 to 15 load those registers.
- R7: The acknowledge of step 14 ends the pass on the next clock: `cal_active` goes low, `conv_done` goes high and `cal_fail` stays low.
- R8: `irq` is high exactly when `conv_done` and the interrupt enable are both set.
- R9: Address 16 reads the plus gain and address 17 the minus gain. Each is the 16-bit wrapped sum of addresses 3 to 8 (plus) or 10 to 15 (minus), shifted right by one, with bit 15 set.
- R10: `conv_done` is cleared by an idle write to address 0 with bit 3 set, or by the start of a new pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| stop_req | input | 1 | Stop-mode entry request |
| cnv_req | output | 1 | Measurement request to the conversion engine |
| cnv_step | output | 4 | Index of the requested measurement |
| cnv_ack | input | 1 | Measurement complete |
| cnv_data | input | 16 | Measurement result |
| cal_active | output | 1 | Pass in progress |
| cal_fail | output | 1 | Last start or pass failed |
| conv_done | output | 1 | Pass completed |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is an abort that lands in the same cycle as an acknowledge. Here the abort must win, and the pending word must not reach its register. The bench drives the engine with no gap, so that it acknowledges every cycle. It then writes in the middle of the pass, which forces that collision. Reading all result registers back afterwards shows that neither the collided word nor the written data was stored. Refused starts are covered by asserting the trigger select, and separately by raising the stop request in the same cycle as the start write.

// File: rtl/adcal_pkg.sv
package adcal_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } cal_state_e;

   localparam int CTL_START_BIT = 0;
   localparam int CTL_TRIG_BIT  = 1;
   localparam int CTL_IEN_BIT   = 2;
   localparam int CTL_CLR_BIT   = 3;

   localparam int STS_ACT_BIT   = 0;
   localparam int STS_TRIG_BIT  = 1;
   localparam int STS_IEN_BIT   = 2;
   localparam int STS_DONE_BIT  = 3;
   localparam int STS_FAIL_BIT  = 4;

endpackage

// File: rtl/adcal_ctrl.sv
module adcal_ctrl
   import adcal_pkg::*;
#(
   parameter int NSTEP  = 15,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ctl,
   input  logic              wr_start,
   input  logic              wr_trig,
   input  logic              wr_ien,
   input  logic              wr_clr,
   input  logic              stop_req,
   input  logic              cnv_ack,
   output logic              running,
   output logic              fail,
   output logic              done,
   output logic              trig_sel,
   output logic              int_en,
   output logic [STEP_W-1:0] step,
   output logic              cap_we
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

   cal_state_e state;
   logic       abort_req;

   assign running   = (state == ST_RUN);
   assign abort_req = running && (wr_en || stop_req);
   assign cap_we    = running && cnv_ack && !abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fail     <= 1'b0;
         done     <= 1'b0;
         trig_sel <= 1'b0;
         int_en   <= 1'b0;
         step     <= '0;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (abort_req) begin
                  state <= ST_IDLE;
                  fail  <= 1'b1;
               end else if (cnv_ack) begin
                  if (step == LAST_STEP) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     step <= step + 1'b1;
                  end
               end
            end
            default: begin
               if (wr_en && wr_ctl) begin
                  trig_sel <= wr_trig;
                  int_en   <= wr_ien;
                  if (wr_clr) done <= 1'b0;
                  if (wr_start) begin
                     if (wr_trig || stop_req) begin
                        fail <= 1'b1;
                     end else begin
                        state <= ST_RUN;
                        step  <= '0;
                        fail  <= 1'b0;
                        done  <= 1'b0;
                     end
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/adcal_store.sv
module adcal_store #(
   parameter int NSTEP  = 15,
   parameter int DATA_W = 16,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_we,
   input  logic [STEP_W-1:0] cap_idx,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [NSTEP-1:0]  sw_hit,
   input  logic [DATA_W-1:0] sw_data,
   output logic [DATA_W-1:0] words [NSTEP]
);

   for (genvar i = 0; i < NSTEP; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i] <= '0;
         end else if (cap_we && (cap_idx == STEP_W'(i))) begin
            words[i] <= cap_data;
         end else if (sw_hit[i]) begin
            words[i] <= sw_data;
         end
      end
   end

endmodule

// File: rtl/adcal_gain.sv
module adcal_gain #(
   parameter int NSTEP  = 15,
   parameter int DATA_W = 16,
   parameter int BASE   = 2,
   parameter int CNT    = 6
) (
   input  logic [DATA_W-1:0] words [NSTEP],
   output logic [DATA_W-1:0] gain
);

   logic [DATA_W-1:0] acc;

   always_comb begin
      acc = '0;
      for (int k = 0; k < CNT; k++) begin
         acc = acc + words[BASE + k];
      end
      gain = (acc >> 1) | {1'b1, {(DATA_W-1){1'b0}}};
   end

endmodule

// File: rtl/adcal_seq.sv
module adcal_seq
   import adcal_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 5,
   parameter int SIDE_WORDS = 7,
   parameter bit GAIN_HW    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              stop_req,
   output logic              cnv_req,
   output logic [$clog2(1+2*SIDE_WORDS)-1:0] cnv_step,
   input  logic              cnv_ack,
   input  logic [DATA_W-1:0] cnv_data,
   output logic              cal_active,
   output logic              cal_fail,
   output logic              conv_done,
   output logic              irq
);

   localparam int NSTEP      = 1 + 2 * SIDE_WORDS;
   localparam int STEP_W     = $clog2(NSTEP);
   localparam int GAIN_P_ADR = NSTEP + 1;
   localparam int GAIN_M_ADR = NSTEP + 2;

   initial begin
      assert (DATA_W >= 8) else $error("adcal_seq: DATA_W too small");
      assert (SIDE_WORDS >= 2) else $error("adcal_seq: SIDE_WORDS below 2");
      assert (GAIN_M_ADR < (1 << ADDR_W)) else $error("adcal_seq: ADDR_W too narrow for map");
   end

   logic              running, fail, done, trig_sel, int_en, cap_we;
   logic [STEP_W-1:0] step;
   logic              wr_ctl;
   logic [NSTEP-1:0]  sw_hit;
   logic [DATA_W-1:0] words [NSTEP];
   logic [DATA_W-1:0] gain_p, gain_m;

   assign wr_ctl = (wr_addr == '0);

   always_comb begin
      for (int k = 0; k < NSTEP; k++) begin
         sw_hit[k] = wr_en && !running && (wr_addr == ADDR_W'(k + 1));
      end
   end

   adcal_ctrl #(
      .NSTEP  (NSTEP),
      .STEP_W (STEP_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_ctl   (wr_ctl),
      .wr_start (wr_data[CTL_START_BIT]),
      .wr_trig  (wr_data[CTL_TRIG_BIT]),
      .wr_ien   (wr_data[CTL_IEN_BIT]),
      .wr_clr   (wr_data[CTL_CLR_BIT]),
      .stop_req (stop_req),
      .cnv_ack  (cnv_ack),
      .running  (running),
      .fail     (fail),
      .done     (done),
      .trig_sel (trig_sel),
      .int_en   (int_en),
      .step     (step),
      .cap_we   (cap_we)
   );

   adcal_store #(
      .NSTEP  (NSTEP),
      .DATA_W (DATA_W),
      .STEP_W (STEP_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_we   (cap_we),
      .cap_idx  (step),
      .cap_data (cnv_data),
      .sw_hit   (sw_hit),
      .sw_data  (wr_data),
      .words    (words)
   );

   if (GAIN_HW) begin : g_gain_hw
      adcal_gain #(
         .NSTEP  (NSTEP),
         .DATA_W (DATA_W),
         .BASE   (2),
         .CNT    (SIDE_WORDS - 1)
      ) u_gain_p (
         .words (words),
         .gain  (gain_p)
      );
      adcal_gain #(
         .NSTEP  (NSTEP),
         .DATA_W (DATA_W),
         .BASE   (SIDE_WORDS + 2),
         .CNT    (SIDE_WORDS - 1)
      ) u_gain_m (
         .words (words),
         .gain  (gain_m)
      );
   end else begin : g_gain_sw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_p <= '0;
            gain_m <= '0;
         end else if (wr_en && !running) begin
            if (wr_addr == ADDR_W'(GAIN_P_ADR)) gain_p <= wr_data;
            if (wr_addr == ADDR_W'(GAIN_M_ADR)) gain_m <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) begin
         rd_data[STS_ACT_BIT]  = running;
         rd_data[STS_TRIG_BIT] = trig_sel;
         rd_data[STS_IEN_BIT]  = int_en;
         rd_data[STS_DONE_BIT] = done;
         rd_data[STS_FAIL_BIT] = fail;
      end else if (rd_addr == ADDR_W'(GAIN_P_ADR)) begin
         rd_data = gain_p;
      end else if (rd_addr == ADDR_W'(GAIN_M_ADR)) begin
         rd_data = gain_m;
      end else begin
         for (int k = 0; k < NSTEP; k++) begin
            if (rd_addr == ADDR_W'(k + 1)) rd_data = words[k];
         end
      end
   end

   assign cnv_req    = running;
   assign cnv_step   = step;
   assign cal_active = running;
   assign cal_fail   = fail;
   assign conv_done  = done;
   assign irq        = done && int_en;

endmodule

// File: rtl/adcal_chk.sv
module adcal_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int STEP_W = 4,
   parameter int NSTEP  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              stop_req,
   input logic              cnv_req,
   input logic [STEP_W-1:0] cnv_step,
   input logic              cnv_ack,
   input logic              cal_active,
   input logic              cal_fail,
   input logic              conv_done,
   input logic              irq
);

   AST_START_OK: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_active && wr_en && wr_addr == '0 && wr_data[0] && !wr_data[1] && !stop_req
      |=> cal_active && !cal_fail && !conv_done); // R1

   AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_active && wr_en && wr_addr == '0 && wr_data[0] && (wr_data[1] || stop_req)
      |=> !cal_active && cal_fail); // R2

   AST_ABORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_active && wr_en |=> !cal_active && cal_fail); // R3

   AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cal_active && stop_req |=> !cal_active && cal_fail); // R4

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_req && !cnv_ack && !wr_en && !stop_req |=> cnv_req && $stable(cnv_step)); // R5

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_req && cnv_ack && !wr_en && !stop_req && cnv_step != STEP_W'(NSTEP - 1)
      |=> cnv_req && cnv_step == $past(cnv_step) + 1'b1); // R5

   AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_req && cnv_ack && !wr_en && !stop_req && cnv_step == STEP_W'(NSTEP - 1)
      |=> !cal_active && conv_done && !cal_fail); // R7

   AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> conv_done); // R8

endmodule

bind adcal_seq adcal_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .STEP_W (STEP_W),
   .NSTEP  (NSTEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .stop_req   (stop_req),
   .cnv_req    (cnv_req),
   .cnv_step   (cnv_step),
   .cnv_ack    (cnv_ack),
   .cal_active (cal_active),
   .cal_fail   (cal_fail),
   .conv_done  (conv_done),
   .irq        (irq)
);

// File: tb/adcal_seq_bench.sv
module adcal_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        stop_req = 1'b0;
   logic        cnv_req;
   logic [3:0]  cnv_step;
   logic        cnv_ack = 1'b0;
   logic [15:0] cnv_data = '0;
   logic        cal_active, cal_fail, conv_done, irq;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int run_id = 0;
   bit resp_en = 1'b0;
   int resp_gap = 0;
   int gap_cnt = 0;

   // behavioural reference state
   bit m_active, m_fail, m_done, m_trig, m_ien;
   int m_step;
   int m_words[15];

   always #5 clk = ~clk;

   adcal_seq u_adcal_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .stop_req(stop_req), .cnv_req(cnv_req),
      .cnv_step(cnv_step), .cnv_ack(cnv_ack), .cnv_data(cnv_data),
      .cal_active(cal_active), .cal_fail(cal_fail), .conv_done(conv_done), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, updated on each edge from the inputs held since the previous negedge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_fail = 0; m_done = 0; m_trig = 0; m_ien = 0; m_step = 0;
         foreach (m_words[i]) m_words[i] = 0;
      end else if (m_active && (wr_en || stop_req)) begin
         m_active = 0; m_fail = 1;
      end else if (m_active && cnv_ack) begin
         m_words[m_step] = int'(cnv_data);
         if (m_step == 14) begin m_active = 0; m_done = 1; end
         else m_step = m_step + 1;
      end else if (!m_active && wr_en) begin
         if (wr_addr == 0) begin
            m_trig = wr_data[1];
            m_ien  = wr_data[2];
            if (wr_data[3]) m_done = 0;
            if (wr_data[0]) begin
               if (wr_data[1] || stop_req) m_fail = 1;
               else begin m_active = 1; m_step = 0; m_fail = 0; m_done = 0; end
            end
         end else if (wr_addr <= 15) begin
            m_words[wr_addr - 1] = int'(wr_data);
         end
      end
   end

   // per-clock comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check(cal_active == m_active, "R1 R3 R4 R7 cal_active", cal_active, m_active);
         check(cal_fail == m_fail, "R2 R3 R4 cal_fail", cal_fail, m_fail);
         check(conv_done == m_done, "R7 R10 conv_done", conv_done, m_done);
         check(irq == (m_done && m_ien), "R8 irq", irq, m_done && m_ien);
         check(cnv_req == m_active, "R5 cnv_req", cnv_req, m_active);
         if (m_active) check(int'(cnv_step) == m_step, "R5 cnv_step", cnv_step, m_step);
      end
   end

   // conversion engine stand-in
   always @(negedge clk) begin
      if (resp_en && cnv_req) begin
         if (gap_cnt >= resp_gap) begin
            cnv_ack  = 1'b1;
            cnv_data = 16'(run_id * 16'h0731 + int'(cnv_step) * 16'h0113 + 16'h0050);
            gap_cnt  = 0;
         end else begin
            cnv_ack = 1'b0;
            gap_cnt++;
         end
      end else begin
         cnv_ack = 1'b0;
         gap_cnt = 0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int addr, input int exp, input string tag);
      @(negedge clk);
      rd_addr = 5'(addr);
      #1;
      check(int'(rd_data) == exp, tag, rd_data, exp);
   endtask

   task automatic wait_idle();
      while (cal_active) @(negedge clk);
   endtask

   function automatic int gain_of(input int base);
      int s = 0;
      for (int k = 0; k < 6; k++) s += m_words[base + k];
      return ((s & 16'hFFFF) >> 1) | 16'h8000;
   endfunction

   task automatic check_all_words();
      for (int k = 0; k < 15; k++) rd_chk(k + 1, m_words[k], "R6 R3 stored word");
      rd_chk(16, gain_of(2), "R9 plus gain");
      rd_chk(17, gain_of(9), "R9 minus gain");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_chk(0, 0, "R1 reset status");
      check(!cal_active && !cnv_req && !irq, "R1 reset outputs", cal_active, 0);

      // R2: start refused with hardware trigger selected
      wr(0, 16'h0003);
      rd_chk(0, 16'h0012, "R2 refused by trigger");
      wr(0, 16'h0000);
      rd_chk(0, 16'h0010, "R2 fail persists");

      // R6: idle software load of the offset
      wr(1, 16'h1234);
      rd_chk(1, 16'h1234, "R6 idle offset write");

      // R1 R7 R8: full pass, no gap, interrupt on
      resp_en = 1; resp_gap = 0; run_id = 1;
      wr(0, 16'h0005);
      check(cal_active && !cal_fail, "R1 started", cal_active, 1);
      wait_idle();
      rd_chk(0, 16'h000C, "R7 done status");
      check(irq == 1'b1, "R8 irq raised", irq, 1);
      check_all_words();

      // full pass with gaps, interrupt off
      run_id = 2; resp_gap = 2;
      wr(0, 16'h0001);
      check(!conv_done, "R10 start clears done", conv_done, 0);
      wait_idle();
      rd_chk(0, 16'h0008, "R7 done second pass");
      check(irq == 1'b0, "R8 irq masked", irq, 0);
      check_all_words();

      // R10: clear done by write
      wr(0, 16'h0008);
      rd_chk(0, 16'h0000, "R10 done cleared");

      // R3: abort by write colliding with an acknowledge
      run_id = 3; resp_gap = 0;
      wr(0, 16'h0001);
      repeat (4) @(negedge clk);
      wr(1, 16'hBEEF);
      rd_chk(0, 16'h0010, "R3 abort by write");
      check_all_words();

      // R4: abort by stop request
      run_id = 4; resp_gap = 1;
      wr(0, 16'h0001);
      repeat (5) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      rd_chk(0, 16'h0010, "R4 abort by stop");
      check_all_words();

      // R2: start refused while stop request is present
      resp_en = 0;
      @(negedge clk);
      stop_req = 1'b1; wr_en = 1'b1; wr_addr = 0; wr_data = 16'h0001;
      @(negedge clk);
      stop_req = 1'b0; wr_en = 1'b0;
      check(!cal_active && cal_fail, "R2 refused by stop", cal_active, 0);

      // R1: restart after failure clears fail
      resp_en = 1; run_id = 5; resp_gap = 1;
      wr(0, 16'h0005);
      check(cal_active && !cal_fail, "R1 restart clears fail", cal_fail, 0);
      wait_idle();
      rd_chk(0, 16'h000C, "R7 done after restart");
      check_all_words();

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule